// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a general-purpose I/O port of up to eight pins controlled through a simple memory-mapped register bus. Each pin has its own register window. The window holds an enable and direction word, a trigger configuration, a stored debounce threshold, the sampled input level, a driver float control, the output level and an interrupt-clear strobe. Incoming pin levels pass through a two-flop synchronizer. A per-pin detector then watches for the configured level or edge condition and latches a status bit.

All latched bits appear together in one port status word. The bits whose interrupt enable is set are ORed onto a single interrupt line. Software services a pin by reading the status word and writing that pin's clear register. A level-sensitive pin raises its bit again for as long as the active level remains.

The bus takes one access per cycle on `bus_req_i`. Writes take effect at the clock edge. Read data appears on `bus_rdata_o` in the cycle after the request.

Top module: `gpio_irq_port`

## Requirements
- R1: Pin n owns the window at byte address n*0x20. Within it: configuration at +0x00, debounce at +0x04, input at +0x08, driver control at +0x0C, output level at +0x10 and interrupt clear at +0x14. The status word is at 0x104. Read data is registered and valid one cycle after the request. Any other address reads as zero, and writes to it change nothing.
- R2: Configuration word fields: bit 0 pin enable, bit 1 direction (1 = output), bits 3:2 trigger type, bit 4 polarity, bit 6 interrupt enable. Bits 5 and 31:7 read as zero. The reset value is zero.
- R3: The debounce register stores an 8-bit value in bits 7:0 and reads it back. Upper bits read zero. The reset value is zero.
- R4: Input register bit 0 returns the pin level after a two-flop synchronizer.
- R5: pin_o[n] follows output-level bit 0. pin_oe_o[n] is high only when the direction bit is 1 and driver-control bit 0 (float) is 0. Float resets to 1 and the output level resets to 0.
- R6: Trigger type 1 (level): with the pin enabled, the status bit sets in every cycle in which the synchronized level equals the polarity bit (1 = high, 0 = low).
- R7: Trigger type 2 (single edge): polarity 1 latches on a rising edge and polarity 0 on a falling edge of the synchronized level. The opposite edge has no effect.
- R8: Trigger type 3 latches on either edge, and the polarity bit has no effect in this mode.
- R9: With trigger type 0, or with the pin enable bit clear, the status bit never sets.
- R10: Writing a value with bit 0 set to the clear register clears that pin's status bit. If the trigger condition holds in the same cycle, the bit stays set, so an active level re-asserts it at once. Otherwise an edge-latched bit holds until it is cleared.
- R11: The status word at 0x104 holds the latched bit of pin n in bit n.
- R12: irq_o is the OR over all pins of status ANDed with interrupt enable. Pins with interrupt enable clear still latch status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, one cycle after request |
| pin_i | input | NUM_PINS | Pad input levels |
| pin_o | output | NUM_PINS | Pad output levels |
| pin_oe_o | output | NUM_PINS | Pad driver enables |
| irq_o | output | 1 | Port interrupt |

## Verification
The assertions check on every cycle that a rising edge under rising-edge mode latches status and that either edge does so in both-edge mode. They also check that a disabled pin or a none-type pin never latches, that the interrupt line is never high without a latched bit, and that unmapped reads return zero. Only the bench scenarios can show the following: a level trigger re-asserting after a clear, polarity having no effect in both-edge mode, the opposite edge being ignored, status latching without an interrupt enable, and the exact register layout and reset values. These are compared cycle by cycle against a behavioural model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_NONE  = 2'd0,
    TRIG_LEVEL = 2'd1,
    TRIG_EDGE  = 2'd2,
    TRIG_BOTH  = 2'd3
  } trig_e;

  typedef struct packed {
    logic  irq_en;
    logic  pol;
    trig_e trig;
    logic  dir;
    logic  en;
  } pin_cfg_t;

  localparam int OFF_W = 5;

  localparam logic [OFF_W-1:0] OFF_CFG  = 5'h00;
  localparam logic [OFF_W-1:0] OFF_DEB  = 5'h04;
  localparam logic [OFF_W-1:0] OFF_IN   = 5'h08;
  localparam logic [OFF_W-1:0] OFF_OCTL = 5'h0C;
  localparam logic [OFF_W-1:0] OFF_OVAL = 5'h10;
  localparam logic [OFF_W-1:0] OFF_CLR  = 5'h14;

  localparam int STATUS_ADDR = 'h104;

  // Configuration word bit positions
  localparam int CB_EN   = 0;
  localparam int CB_DIR  = 1;
  localparam int CB_TRIG = 2;
  localparam int CB_POL  = 4;
  localparam int CB_IE   = 6;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEB_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [DEB_W-1:0] wdata_i,
  input  logic             sync_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic             status_o,
  output logic             irq_en_o,
  output logic             pin_o,
  output logic             pin_oe_o
);
  pin_cfg_t         cfg_q;
  logic [DEB_W-1:0] deb_q;
  logic             float_q, oval_q, prev_q, status_q;
  logic             hit, clr;
  logic             unused_wbit5;

  assign unused_wbit5 = wdata_i[5];

  always_comb begin
    hit = 1'b0;
    if (cfg_q.en) begin
      case (cfg_q.trig)
        TRIG_LEVEL: hit = (sync_i == cfg_q.pol);
        TRIG_EDGE:  hit = cfg_q.pol ? (sync_i & ~prev_q) : (~sync_i & prev_q);
        TRIG_BOTH:  hit = sync_i ^ prev_q;
        default:    hit = 1'b0;
      endcase
    end
  end

  assign clr = wr_en_i && (off_i == OFF_CLR) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      deb_q    <= '0;
      float_q  <= 1'b1;
      oval_q   <= 1'b0;
      prev_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      prev_q   <= sync_i;
      // a fresh hit wins over a clear in the same cycle
      status_q <= (status_q & ~clr) | hit;
      if (wr_en_i) begin
        case (off_i)
          OFF_CFG: begin
            cfg_q.en     <= wdata_i[CB_EN];
            cfg_q.dir    <= wdata_i[CB_DIR];
            cfg_q.trig   <= trig_e'(wdata_i[CB_TRIG +: 2]);
            cfg_q.pol    <= wdata_i[CB_POL];
            cfg_q.irq_en <= wdata_i[CB_IE];
          end
          OFF_DEB:  deb_q   <= wdata_i;
          OFF_OCTL: float_q <= wdata_i[0];
          OFF_OVAL: oval_q  <= wdata_i[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (off_i)
      OFF_CFG: begin
        rd_data_o[CB_EN]          = cfg_q.en;
        rd_data_o[CB_DIR]         = cfg_q.dir;
        rd_data_o[CB_TRIG +: 2]   = cfg_q.trig;
        rd_data_o[CB_POL]         = cfg_q.pol;
        rd_data_o[CB_IE]          = cfg_q.irq_en;
      end
      OFF_DEB:  rd_data_o[DEB_W-1:0] = deb_q;
      OFF_IN:   rd_data_o[0] = sync_i;
      OFF_OCTL: rd_data_o[0] = float_q;
      OFF_OVAL: rd_data_o[0] = oval_q;
      default:  rd_data_o = '0;
    endcase
  end

  assign status_o = status_q;
  assign irq_en_o = cfg_q.irq_en;
  assign pin_o    = oval_q;
  assign pin_oe_o = cfg_q.dir & ~float_q;

  assert_rise_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.en && cfg_q.trig == TRIG_EDGE && cfg_q.pol && $rose(sync_i)) |=> status_q);

  assert_both_latch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.en && cfg_q.trig == TRIG_BOTH && ($rose(sync_i) || $fell(sync_i))) |=> status_q);

  assert_quiet_when_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!cfg_q.en || cfg_q.trig == TRIG_NONE) && !status_q) |=> !status_q);

  assert_edge_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q && !(wr_en_i && off_i == OFF_CLR)) |=> status_q);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int DEB_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  localparam int IDX_W   = 3;  // window 0x20, status at 0x100 -> at most 8 pins
  localparam int HI_LSB  = OFF_W + IDX_W;

  logic [IDX_W-1:0]    idx;
  logic [OFF_W-1:0]    off;
  logic                in_win, status_sel;
  logic [NUM_PINS-1:0] sync_v, status_v, irq_en_v, wr_en_v;
  logic [DATA_W-1:0]   pin_rd [NUM_PINS];
  logic [DATA_W-1:0]   rd_d, rdata_q;
  logic                unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DATA_W-1:DEB_W];
  assign idx = bus_addr_i[OFF_W +: IDX_W];
  assign off = bus_addr_i[OFF_W-1:0];

  always_comb begin
    in_win     = (bus_addr_i[ADDR_W-1:HI_LSB] == '0) && (int'(idx) < NUM_PINS);
    status_sel = (bus_addr_i == ADDR_W'(STATUS_ADDR));
  end

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_v)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    assign wr_en_v[n] = bus_req_i && bus_we_i && in_win && (idx == IDX_W'(n));

    gpio_pin_ctrl #(.DATA_W(DATA_W), .DEB_W(DEB_W)) u_pin (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en_v[n]),
      .off_i    (off),
      .wdata_i  (bus_wdata_i[DEB_W-1:0]),
      .sync_i   (sync_v[n]),
      .rd_data_o(pin_rd[n]),
      .status_o (status_v[n]),
      .irq_en_o (irq_en_v[n]),
      .pin_o    (pin_o[n]),
      .pin_oe_o (pin_oe_o[n])
    );
  end

  always_comb begin
    rd_d = '0;
    if (status_sel) begin
      rd_d[NUM_PINS-1:0] = status_v;
    end else if (in_win) begin
      for (int n = 0; n < NUM_PINS; n++) begin
        if (idx == IDX_W'(n)) rd_d = pin_rd[n];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      rdata_q <= '0;
    else if (bus_req_i && !bus_we_i)  rdata_q <= rd_d;
    else                              rdata_q <= '0;
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = |(status_v & irq_en_v);

  assert_unmapped_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && !in_win && !status_sel) |=> (bus_rdata_o == '0));

  assert_irq_needs_status_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_v != '0));
endmodule

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;
  localparam int NP = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [11:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [NP-1:0] pin_i = '0;
  logic [NP-1:0] pin_o, pin_oe_o;
  logic        irq_o;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  gpio_irq_port dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o), .irq_o(irq_o)
  );

  // ---------------- behavioural reference model ----------------
  bit [NP-1:0] m_en, m_dir, m_pol, m_ie, m_flt, m_ov, m_s1, m_s2, m_pv, m_st;
  bit [1:0]    m_ty  [NP];
  bit [7:0]    m_deb [NP];
  bit [31:0]   m_rd;
  bit          m_rdv;
  bit [11:0]   m_rda;

  function automatic bit [31:0] model_read(input bit [11:0] a);
    int p = a / 32;
    int o = a % 32;
    if (a == 12'h104) return {24'd0, m_st};
    if (a >= 12'h100) return 0;
    case (o)
      0:  return {25'd0, m_ie[p], 1'b0, m_pol[p], m_ty[p], m_dir[p], m_en[p]};
      4:  return {24'd0, m_deb[p]};
      8:  return {31'd0, m_s2[p]};
      12: return {31'd0, m_flt[p]};
      16: return {31'd0, m_ov[p]};
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input bit [11:0] a);
    if (a == 12'h104) return "R11";
    if (a >= 12'h100) return "R1";
    case (a % 32)
      0: return "R2"; 4: return "R3"; 8: return "R4";
      12, 16: return "R5";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en <= '0; m_dir <= '0; m_pol <= '0; m_ie <= '0; m_flt <= '1; m_ov <= '0;
      m_s1 <= '0; m_s2 <= '0; m_pv <= '0; m_st <= '0; m_rdv <= 0; m_rd <= '0;
      for (int n = 0; n < NP; n++) begin m_ty[n] <= 0; m_deb[n] <= 0; end
    end else begin
      m_rdv <= bus_req_i && !bus_we_i;
      m_rda <= bus_addr_i;
      m_rd  <= model_read(bus_addr_i);
      m_s1  <= pin_i;
      m_s2  <= m_s1;
      m_pv  <= m_s2;
      for (int n = 0; n < NP; n++) begin
        bit h, c, w;
        h = 0;
        if (m_en[n]) begin
          if (m_ty[n] == 1) h = (m_s2[n] == m_pol[n]);
          else if (m_ty[n] == 2) h = m_pol[n] ? (m_s2[n] && !m_pv[n]) : (!m_s2[n] && m_pv[n]);
          else if (m_ty[n] == 3) h = (m_s2[n] != m_pv[n]);
        end
        w = bus_req_i && bus_we_i && bus_addr_i < 12'h100 && (bus_addr_i / 32) == n;
        c = w && (bus_addr_i % 32) == 20 && bus_wdata_i[0];
        m_st[n] <= (m_st[n] && !c) || h;
        if (w) begin
          case (bus_addr_i % 32)
            0: begin
              m_en[n] <= bus_wdata_i[0]; m_dir[n] <= bus_wdata_i[1];
              m_ty[n] <= bus_wdata_i[3:2]; m_pol[n] <= bus_wdata_i[4];
              m_ie[n] <= bus_wdata_i[6];
            end
            4:  m_deb[n] <= bus_wdata_i[7:0];
            12: m_flt[n] <= bus_wdata_i[0];
            16: m_ov[n]  <= bus_wdata_i[0];
            default: ;
          endcase
        end
      end
    end
  end

  task automatic check(input string tag, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni) begin
      check("R12 irq", {31'd0, irq_o}, {31'd0, |(m_st & m_ie)});
      check("R5 pin_o", {24'd0, pin_o}, {24'd0, m_ov});
      check("R5 pin_oe", {24'd0, pin_oe_o}, {24'd0, m_dir & ~m_flt});
      if (m_rdv) check(tag_of(m_rda), bus_rdata_o, m_rd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input bit [11:0] a, input bit [31:0] d);
    @(negedge clk_i);
    bus_req_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_req_i = 0; bus_we_i = 0;
  endtask

  task automatic rd_chk(input bit [11:0] a, input bit [31:0] mask, input bit [31:0] exp,
                        input string tag);
    @(negedge clk_i);
    bus_req_i = 1; bus_we_i = 0; bus_addr_i = a;
    @(negedge clk_i);
    bus_req_i = 0;
    check(tag, bus_rdata_o & mask, exp);
  endtask

  task automatic set_pin(input int n, input bit v);
    @(negedge clk_i);
    pin_i[n] = v;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // reset values
    rd_chk(12'h000, 32'hFFFF_FFFF, 0, "R2 cfg reset");
    rd_chk(12'h0EC, 32'hFFFF_FFFF, 1, "R5 float reset");
    rd_chk(12'h104, 32'hFFFF_FFFF, 0, "R11 status reset");
    check("R12 irq reset", {31'd0, irq_o}, 0);
    // field layout and reserved bits
    wr(12'h060, 32'hFFFF_FFFF);
    rd_chk(12'h060, 32'hFFFF_FFFF, 32'h5F, "R2 cfg fields");
    wr(12'h060, 0);
    wr(12'h064, 32'h0000_01A5);
    rd_chk(12'h064, 32'hFFFF_FFFF, 32'hA5, "R3 debounce");
    // output driver
    wr(12'h040, 32'h3); wr(12'h050, 1); wr(12'h04C, 0);
    @(negedge clk_i);
    check("R5 drive", {30'd0, pin_oe_o[2], pin_o[2]}, 2'b11);
    wr(12'h04C, 1);
    @(negedge clk_i);
    check("R5 float", {31'd0, pin_oe_o[2]}, 0);
    // input sampling
    set_pin(5, 1);
    rd_chk(12'h0A8, 32'hFFFF_FFFF, 1, "R4 input");
    // rising edge, pin 0
    wr(12'h000, 32'h59);
    set_pin(0, 1);
    rd_chk(12'h104, 32'h1, 1, "R7 rise");
    check("R12 irq on", {31'd0, irq_o}, 1);
    wr(12'h014, 1);
    rd_chk(12'h104, 32'h1, 0, "R10 clear edge");
    set_pin(0, 0);
    rd_chk(12'h104, 32'h1, 0, "R7 fall ignored");
    // falling edge, pin 1
    wr(12'h020, 32'h49);
    set_pin(1, 1);
    rd_chk(12'h104, 32'h2, 0, "R7 rise ignored");
    set_pin(1, 0);
    rd_chk(12'h104, 32'h2, 2, "R7 fall");
    repeat (3) @(negedge clk_i);
    rd_chk(12'h104, 32'h2, 2, "R10 edge holds");
    wr(12'h034, 1);
    // both edges, pin 4, polarity 1 then 0, no interrupt enable
    wr(12'h080, 32'h1D);
    set_pin(4, 1);
    rd_chk(12'h104, 32'h10, 32'h10, "R8 both rise");
    check("R12 latch without irq", {31'd0, irq_o}, 0);
    wr(12'h094, 1);
    wr(12'h080, 32'h0D);
    set_pin(4, 0);
    rd_chk(12'h104, 32'h10, 32'h10, "R8 both fall pol ignored");
    wr(12'h094, 1);
    // disabled and none-type pins
    wr(12'h060, 32'h18);
    set_pin(3, 1); set_pin(3, 0);
    wr(12'h060, 32'h01);
    set_pin(3, 1);
    rd_chk(12'h104, 32'h8, 0, "R9 no latch");
    // level high, pin 6
    wr(12'h0C0, 32'h55);
    set_pin(6, 1);
    rd_chk(12'h104, 32'h40, 32'h40, "R6 level high");
    wr(12'h0D4, 1);
    rd_chk(12'h104, 32'h40, 32'h40, "R10 level reasserts");
    set_pin(6, 0);
    wr(12'h0D4, 1);
    rd_chk(12'h104, 32'h40, 0, "R10 level cleared");
    // level low, pin 7
    wr(12'h0E0, 32'h45);
    repeat (2) @(negedge clk_i);
    rd_chk(12'h104, 32'h80, 32'h80, "R6 level low");
    wr(12'h0E0, 0); wr(12'h0F4, 1);
    // unmapped addresses
    rd_chk(12'h018, 32'hFFFF_FFFF, 0, "R1 hole");
    rd_chk(12'h100, 32'hFFFF_FFFF, 0, "R1 gap");
    rd_chk(12'h200, 32'hFFFF_FFFF, 0, "R1 high");
    wr(12'h104, 32'hFF);
    rd_chk(12'h104, 32'h80, 0, "R1 status write ignored");
    repeat (4) @(negedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule